// File: doc/BRIEF.md
# Set/Clear GPIO Port with Implicit Direction

This block is a general-purpose I/O port of 32 pins that sits on a simple 32-bit register bus. The bus has an address, a write enable, write data and combinational read data. Software never writes a direction register.

To drive a pin, software writes a one for that pin into either the set word or the clear word. That one write updates the output latch and also turns the pin into an output. To give a pin back to the outside world, software writes a one for it into the tristate-release word.

The pin-state word reads as zero until software has written the arming word at least once. After that first write it returns the pad inputs through a two-stage synchroniser. At some offsets a read and a write reach different storage. At the drive-release offset, a read returns the output-enable latch while a write releases pins. At the set offset, a read returns the output latch. At the arming offset, a read returns the synchronised pins.

Top module: `gpio_setclr_port`

## Requirements
- R1: Reset clears the output latch, the output-enable latch and the arming flag, so `pad_out` and `pad_oe` are all zeros and every pin is an undriven input.
- R2: A write to byte offset 0x108 ORs the write data into the output latch and also ORs it into the output-enable latch.
- R3: A write to byte offset 0x10C clears in the output latch every bit that is one in the write data, and ORs the write data into the output-enable latch.
- R4: A write to byte offset 0x100 clears in the output-enable latch every bit that is one in the write data, and leaves the output latch unchanged.
- R5: Write-data bits that are zero in a write to 0x100, 0x108 or 0x10C leave the matching latch bits unchanged.
- R6: A read at 0x100 returns the output-enable latch. A read at 0x108 returns the output latch, bit n for pin n.
- R7: Until the arming word has been written, a read at 0x110 returns zero whatever `pad_in` carries.
- R8: A write of any value, zero included, to 0x110 sets a sticky arming flag that only reset clears. Once armed, a read at 0x110 returns `pad_in` as it was two rising clock edges earlier.
- R9: Offset 0x10C is write-only and reads as zero. Reads from any other unmapped offset return zero, and writes to unmapped offsets change nothing.
- R10: `pad_out` and `pad_oe` are the latch contents. They change on the rising edge that accepts the write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_addr | input | 12 | Byte offset of the access |
| bus_we | input | 1 | Write strobe for the current cycle |
| bus_wdata | input | 32 | Write data, bit n for pin n |
| bus_rdata | output | 32 | Combinational read data for `bus_addr` |
| pad_in | input | 32 | Levels seen at the pads |
| pad_out | output | 32 | Output latch to the pad drivers |
| pad_oe | output | 32 | Output enable per pad, 1 = driven |

## Verification
On every cycle, the assertions check the following:
- After a set or clear write, the written pins are enabled and hold the requested level.
- A release write disables the written pins without moving the output latch.
- Without a strobe, neither latch moves.
- The arming flag never drops.
- Unmapped or unarmed reads give zero.
- At most one write strobe fires at a time.

Only the bench scenarios can show two things. The first is the exact two-edge latency from a pad change to the pin-state read. The second is that a write of zero to the arming word still arms sampling. The bench also compares the pads and read data against a behavioural model on every cycle.

// File: rtl/gpio_sc_pkg.sv
package gpio_sc_pkg;
  localparam int unsigned OFS_DRVREL = 32'h100;
  localparam int unsigned OFS_SETOUT = 32'h108;
  localparam int unsigned OFS_CLROUT = 32'h10C;
  localparam int unsigned OFS_PINARM = 32'h110;

  function automatic logic [31:0] fn_or_in(input logic [31:0] cur, input logic [31:0] msk);
    return cur | msk;
  endfunction

  function automatic logic [31:0] fn_knock_out(input logic [31:0] cur, input logic [31:0] msk);
    return cur & ~msk;
  endfunction
endpackage

// File: rtl/gpio_sc_decode.sv
module gpio_sc_decode #(
  parameter int ADDR_W = 12
) (
  input  logic [ADDR_W-1:0] addr,
  input  logic              we,
  output logic              hit_rel,
  output logic              hit_set,
  output logic              hit_clr,
  output logic              hit_arm,
  output logic              wr_rel,
  output logic              wr_set,
  output logic              wr_clr,
  output logic              wr_arm
);
  import gpio_sc_pkg::*;

  always_comb begin
    hit_rel = (addr == ADDR_W'(OFS_DRVREL));
    hit_set = (addr == ADDR_W'(OFS_SETOUT));
    hit_clr = (addr == ADDR_W'(OFS_CLROUT));
    hit_arm = (addr == ADDR_W'(OFS_PINARM));
    wr_rel  = we & hit_rel;
    wr_set  = we & hit_set;
    wr_clr  = we & hit_clr;
    wr_arm  = we & hit_arm;
  end
endmodule

// File: rtl/gpio_sc_latches.sv
module gpio_sc_latches #(
  parameter int PIN_N = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_set,
  input  logic             wr_clr,
  input  logic             wr_rel,
  input  logic [PIN_N-1:0] mask,
  output logic [PIN_N-1:0] out_q,
  output logic [PIN_N-1:0] oe_q
);
  import gpio_sc_pkg::*;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_q <= '0;
      oe_q  <= '0;
    end else if (wr_set) begin
      out_q <= PIN_N'(fn_or_in(32'(out_q), 32'(mask)));
      oe_q  <= PIN_N'(fn_or_in(32'(oe_q), 32'(mask)));
    end else if (wr_clr) begin
      out_q <= PIN_N'(fn_knock_out(32'(out_q), 32'(mask)));
      oe_q  <= PIN_N'(fn_or_in(32'(oe_q), 32'(mask)));
    end else if (wr_rel) begin
      oe_q  <= PIN_N'(fn_knock_out(32'(oe_q), 32'(mask)));
    end
  end

  assert_set_R2: assert property (@(posedge clk) disable iff (!rst_n)
    wr_set |=> (((out_q & $past(mask)) == $past(mask)) && ((oe_q & $past(mask)) == $past(mask))));
  assert_clr_R3: assert property (@(posedge clk) disable iff (!rst_n)
    wr_clr |=> (((out_q & $past(mask)) == '0) && ((oe_q & $past(mask)) == $past(mask))));
  assert_rel_R4: assert property (@(posedge clk) disable iff (!rst_n)
    wr_rel |=> (((oe_q & $past(mask)) == '0) && $stable(out_q)));
  assert_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
    !(wr_set || wr_clr || wr_rel) |=> ($stable(out_q) && $stable(oe_q)));
  assert_keep_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_set || wr_clr || wr_rel) |=> (((out_q ^ $past(out_q)) & ~$past(mask)) == '0));
endmodule

// File: rtl/gpio_sc_insync.sv
module gpio_sc_insync #(
  parameter int PIN_N       = 32,
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_arm,
  input  logic [PIN_N-1:0] pins,
  output logic             armed,
  output logic [PIN_N-1:0] pins_sync
);
  logic [PIN_N-1:0] stage_q [SYNC_STAGES];

  generate
    for (genvar s = 0; s < SYNC_STAGES; s++) begin : g_stage
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) stage_q[s] <= '0;
        else if (s == 0) stage_q[s] <= pins;
        else stage_q[s] <= stage_q[(s == 0) ? 0 : s-1];
      end
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      armed <= 1'b0;
    else if (wr_arm) armed <= 1'b1;
  end

  assign pins_sync = stage_q[SYNC_STAGES-1];

  assert_sticky_R8: assert property (@(posedge clk) disable iff (!rst_n)
    armed |=> armed);
  assert_arm_R8: assert property (@(posedge clk) disable iff (!rst_n)
    wr_arm |=> armed);
endmodule

// File: rtl/gpio_setclr_port.sv
module gpio_setclr_port #(
  parameter int ADDR_W      = 12,
  parameter int DATA_W      = 32,
  parameter int PIN_N       = 32,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_we,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  input  logic [PIN_N-1:0]  pad_in,
  output logic [PIN_N-1:0]  pad_out,
  output logic [PIN_N-1:0]  pad_oe
);
  localparam int MASK_W = (PIN_N < DATA_W) ? PIN_N : DATA_W;

  logic hit_rel, hit_set, hit_clr, hit_arm;
  logic wr_rel, wr_set, wr_clr, wr_arm;
  logic armed;
  logic [PIN_N-1:0] pins_sync, out_q, oe_q, wmask;
  logic any_hit;

  assign wmask = PIN_N'(bus_wdata[MASK_W-1:0]);

  gpio_sc_decode #(.ADDR_W(ADDR_W)) u_dec (
    .addr(bus_addr), .we(bus_we),
    .hit_rel(hit_rel), .hit_set(hit_set), .hit_clr(hit_clr), .hit_arm(hit_arm),
    .wr_rel(wr_rel), .wr_set(wr_set), .wr_clr(wr_clr), .wr_arm(wr_arm)
  );

  gpio_sc_latches #(.PIN_N(PIN_N)) u_lat (
    .clk(clk), .rst_n(rst_n), .wr_set(wr_set), .wr_clr(wr_clr), .wr_rel(wr_rel),
    .mask(wmask), .out_q(out_q), .oe_q(oe_q)
  );

  gpio_sc_insync #(.PIN_N(PIN_N), .SYNC_STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n), .wr_arm(wr_arm), .pins(pad_in),
    .armed(armed), .pins_sync(pins_sync)
  );

  assign any_hit = hit_rel | hit_set | hit_arm;

  always_comb begin
    bus_rdata = '0;
    if (hit_rel)              bus_rdata = DATA_W'(oe_q);
    else if (hit_set)         bus_rdata = DATA_W'(out_q);
    else if (hit_arm && armed) bus_rdata = DATA_W'(pins_sync);
  end

  assign pad_out = out_q;
  assign pad_oe  = oe_q;

  assert_unarmed_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (hit_arm && !armed) |-> (bus_rdata == '0));
  assert_unmapped_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !any_hit |-> (bus_rdata == '0));
  assert_onestrobe_R9: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({wr_rel, wr_set, wr_clr, wr_arm}));
  assert_rst_R1: assert property (@(posedge clk)
    !rst_n |-> (pad_oe == '0 && pad_out == '0));
endmodule

// File: tb/tb_gpio_setclr_port.sv
module tb_gpio_setclr_port;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [11:0] bus_addr = '0;
  logic        bus_we = 1'b0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic [31:0] pad_in = '0;
  logic [31:0] pad_out, pad_oe;

  int total = 0;
  int bad = 0;
  bit done = 0;

  gpio_setclr_port dut (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_we(bus_we),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .pad_in(pad_in),
    .pad_out(pad_out), .pad_oe(pad_oe)
  );

  always #5 clk = ~clk;

  // behavioural reference
  logic [31:0] m_out = '0, m_oe = '0;
  bit m_arm = 0;
  logic [31:0] hist[$];

  always @(posedge clk) begin
    if (!rst_n) begin
      m_out = '0; m_oe = '0; m_arm = 0; hist.delete();
    end else begin
      if (bus_we) begin
        if (bus_addr == 12'h108) begin m_out = m_out | bus_wdata; m_oe = m_oe | bus_wdata; end
        else if (bus_addr == 12'h10C) begin m_out = m_out & ~bus_wdata; m_oe = m_oe | bus_wdata; end
        else if (bus_addr == 12'h100) m_oe = m_oe & ~bus_wdata;
        else if (bus_addr == 12'h110) m_arm = 1;
      end
      hist.push_back(pad_in);
      if (hist.size() > 4) void'(hist.pop_front());
    end
  end

  function automatic logic [31:0] exp_rd(input logic [11:0] a);
    if (a == 12'h100) return m_oe;
    if (a == 12'h108) return m_out;
    if (a == 12'h110) return (m_arm && hist.size() >= 2) ? hist[hist.size()-2] : 32'h0;
    return 32'h0;
  endfunction

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h t=%0t", tag, act, exp, $time);
    end
  endtask

  always @(negedge clk) begin
    #2;
    if (rst_n && !done) begin
      chk("R10 pad_out", pad_out, m_out);
      chk("R10 pad_oe", pad_oe, m_oe);
      chk("R6 rdata", bus_rdata, exp_rd(bus_addr));
    end
  end

  task automatic wr(input logic [11:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_addr = a; bus_we = 1'b1; bus_wdata = d;
    @(negedge clk);
    bus_we = 1'b0;
    #3;
  endtask

  task automatic rd(input logic [11:0] a, output logic [31:0] d);
    @(negedge clk);
    bus_addr = a; bus_we = 1'b0;
    #3;
    d = bus_rdata;
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    #3;
  endtask

  initial begin
    #2_000_000;
    bad++; total++;
    $display("FAIL watchdog actual=hung expected=finished");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    logic [31:0] v;
    do_reset();
    chk("R1 pad_out", pad_out, 32'h0);
    chk("R1 pad_oe", pad_oe, 32'h0);
    rd(12'h100, v); chk("R1 oe read", v, 32'h0);

    pad_in = 32'hDEAD_BEEF;
    repeat (3) @(negedge clk);
    rd(12'h110, v); chk("R7 unarmed read", v, 32'h0);

    wr(12'h108, 32'h0000_00F5);
    chk("R2 out", pad_out, 32'h0000_00F5);
    chk("R2 oe", pad_oe, 32'h0000_00F5);
    wr(12'h10C, 32'h0000_0014);
    chk("R3 out", pad_out, 32'h0000_00E1);
    chk("R3 oe", pad_oe, 32'h0000_00F5);
    wr(12'h10C, 32'hF000_0000);
    chk("R3 implicit dir out", pad_out, 32'h0000_00E1);
    chk("R3 implicit dir oe", pad_oe, 32'hF000_00F5);
    wr(12'h100, 32'h0000_00F0);
    chk("R4 oe", pad_oe, 32'hF000_0005);
    chk("R4 out kept", pad_out, 32'h0000_00E1);
    rd(12'h108, v); chk("R6 out read", v, 32'h0000_00E1);
    rd(12'h100, v); chk("R6 oe read", v, 32'hF000_0005);

    wr(12'h108, 32'h0); wr(12'h10C, 32'h0); wr(12'h100, 32'h0);
    chk("R5 out", pad_out, 32'h0000_00E1);
    chk("R5 oe", pad_oe, 32'hF000_0005);

    wr(12'h104, 32'hFFFF_FFFF); wr(12'h000, 32'hFFFF_FFFF); wr(12'h118, 32'hFFFF_FFFF);
    chk("R9 out", pad_out, 32'h0000_00E1);
    chk("R9 oe", pad_oe, 32'hF000_0005);
    rd(12'h10C, v); chk("R9 clr read", v, 32'h0);
    rd(12'h104, v); chk("R9 unmapped read", v, 32'h0);
    rd(12'h110, v); chk("R7 still unarmed", v, 32'h0);

    pad_in = 32'hA5A5_1234;
    wr(12'h110, 32'h0);
    repeat (2) @(negedge clk);
    rd(12'h110, v); chk("R8 armed read", v, 32'hA5A5_1234);
    @(negedge clk);
    pad_in = 32'h0F0F_7777;
    @(negedge clk); #3;
    chk("R8 one edge", bus_rdata, 32'hA5A5_1234);
    @(negedge clk); #3;
    chk("R8 two edges", bus_rdata, 32'h0F0F_7777);
    wr(12'h110, 32'hFFFF_FFFF);
    rd(12'h110, v); chk("R8 sticky", v, 32'h0F0F_7777);

    for (int i = 0; i < 400; i++) begin
      @(negedge clk);
      pad_in = $urandom;
      bus_we = ($urandom_range(0, 2) == 0);
      case ($urandom_range(0, 5))
        0: bus_addr = 12'h100; 1: bus_addr = 12'h108; 2: bus_addr = 12'h10C;
        3: bus_addr = 12'h110; 4: bus_addr = 12'h104; default: bus_addr = 12'($urandom);
      endcase
      bus_wdata = $urandom;
    end
    @(negedge clk); bus_we = 1'b0;

    do_reset();
    chk("R1 re-reset out", pad_out, 32'h0);
    chk("R1 re-reset oe", pad_oe, 32'h0);
    rd(12'h110, v); chk("R1 re-reset disarmed", v, 32'h0);

    done = 1;
    @(negedge clk);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule